// File: doc/BRIEF.md
# Trace timestamp control register

This block is one system-register slice of a trace unit. It stores the event selection that decides when a global timestamp is requested, and it answers register accesses that arrive as system-instruction encodings. For each access strobe that carries its encoding, it settles in the same cycle on one of three outcomes: the access completes, the access is undefined, or the access traps to a named exception level. A completed read returns the register image. A completed write updates the stored fields.

Trap resolution follows the current exception level. Per-level trace-trap control bits are tested in a fixed priority, and the checks on the EL2 and EL3 bits apply only when that level is present and running the 64-bit state. The stored selector chooses either one bit of a 32-bit resource status vector or one bit of an externally computed 16-bit pair-result vector. The chosen bit is registered once and drives the timestamp-request output.

The block takes as inputs the number of implemented selector pairs and the timestamp size. When the pair count is zero, the selector fields are reserved. When the timestamp size is zero, the register is absent.

Top module: `ts_ctl_reg`

## Requirements
- R1: After reset, with no strobe, acc_done_o, acc_undef_o, acc_trap_o, wr_ack_o, wr_unpred_o and ts_req_o are all 0.
- R2: Only a strobe whose encoding is op0=2'b10, op1=3'b001, CRn=4'b0000, CRm=4'b1100 and op2=3'b000 produces a response. Any other strobe gets no response and does not change the register.
- R3: For a matching strobe, exactly one of acc_done_o, acc_undef_o and acc_trap_o is 1, in the same cycle. When acc_trap_o is 1, trap_ec_o is 6'h18.
- R4: A matching access with cur_el_i=0 is undefined.
- R5: A matching access at any exception level is undefined while cfg_ts_size_i is 0.
- R6: At EL1 the checks run in this order, and the first match wins:
  - el1_tta_i traps to EL1 (trap_el_o=1).
  - el2_tta_i traps to EL2 when el2_en_i=1 and el2_aa32_i=0.
  - el3_tta_i traps to EL3 when el3_present_i=1 and el3_aa32_i=0.
  - If none of these matches, the access completes.
- R7: At EL2, el2_tta_i traps to EL2 whatever el2_en_i is. If it does not, the EL3 check of R6 applies, and if that does not match either, the access completes.
- R8: At EL3, only el3_tta_i is examined; it traps to EL3. The EL1 and EL2 trap bits have no effect there.
- R9: Read data holds the event type at bit 7 and the selector at bits 4:0. Every other bit reads 0. When the type is 1 (pair), selector bit 4 reads 0.
- R10: While cfg_pairs_i is 0, the type and selector are reserved: written values are discarded, reads return 0, and ts_req_o is 0.
- R11: A write that completes while unit_idle_i is 0 raises wr_unpred_o together with wr_ack_o, and the register is still updated.
- R12: The register changes only on a completed write. Trapped or undefined writes leave it unchanged.
- R13: With type 0, ts_req_o equals res_status_i[sel] one cycle later. It is 0 when sel is at or above 2*cfg_pairs_i.
- R14: With type 1, ts_req_o equals pair_result_i[sel[3:0]] one cycle later. It is 0 when sel[3:0] is at or above cfg_pairs_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Access strobe |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_op0_i | input | 2 | Encoding op0 |
| acc_op1_i | input | 3 | Encoding op1 |
| acc_crn_i | input | 4 | Encoding CRn |
| acc_crm_i | input | 4 | Encoding CRm |
| acc_op2_i | input | 3 | Encoding op2 |
| acc_wdata_i | input | 64 | Write data |
| cur_el_i | input | 2 | Current exception level |
| el1_tta_i | input | 1 | EL1 trace trap control |
| el2_tta_i | input | 1 | EL2 trace trap control |
| el3_tta_i | input | 1 | EL3 trace trap control |
| el2_en_i | input | 1 | EL2 enabled |
| el2_aa32_i | input | 1 | EL2 uses 32-bit state |
| el3_present_i | input | 1 | EL3 implemented |
| el3_aa32_i | input | 1 | EL3 uses 32-bit state |
| unit_idle_i | input | 1 | Trace unit idle |
| cfg_ts_size_i | input | 5 | Timestamp size, 0 = register absent |
| cfg_pairs_i | input | 5 | Implemented selector pairs |
| res_status_i | input | 32 | Single resource selector status |
| pair_result_i | input | 16 | Pair Boolean results |
| acc_done_o | output | 1 | Access completes |
| acc_undef_o | output | 1 | Access undefined |
| acc_trap_o | output | 1 | Access traps |
| trap_el_o | output | 2 | Trap target level |
| trap_ec_o | output | 6 | Trap syndrome class |
| rdata_o | output | 64 | Read data on a completed read |
| wr_ack_o | output | 1 | Write completed |
| wr_unpred_o | output | 1 | Write completed while not idle |
| ts_req_o | output | 1 | Timestamp request |

## Verification
A completed write and the timestamp-request path can fall in the same cycle. The registered request is sampled from the selection that holds before the write's clock edge. The bench provokes this by holding a status bit high under the old selector and rewriting the selector to an index whose bit is low. It then checks that ts_req_o keeps the old selection in the cycle right after the write and follows the new selection one cycle later.

// File: rtl/ts_ctl_pkg.sv
`timescale 1ns/1ps
package ts_ctl_pkg;
  localparam int REG_W     = 64;
  localparam int SEL_W     = 5;
  localparam int NUM_SEL   = 1 << SEL_W;
  localparam int PAIR_W    = SEL_W - 1;
  localparam int NUM_PAIRS = 1 << PAIR_W;
  localparam int PCNT_W    = SEL_W;
  localparam int TS_W      = 5;
  localparam int TYPE_POS  = 7;

  localparam logic [1:0] ENC_OP0 = 2'b10;
  localparam logic [2:0] ENC_OP1 = 3'b001;
  localparam logic [3:0] ENC_CRN = 4'b0000;
  localparam logic [3:0] ENC_CRM = 4'b1100;
  localparam logic [2:0] ENC_OP2 = 3'b000;

  localparam logic [5:0] TRAP_EC = 6'h18;

  typedef enum logic [1:0] {
    LVL0 = 2'd0,
    LVL1 = 2'd1,
    LVL2 = 2'd2,
    LVL3 = 2'd3
  } lvl_e;

  typedef struct packed {
    logic             evt_pair;
    logic [SEL_W-1:0] evt_sel;
  } ts_fields_t;

  // reserved-field masking shared by write, read and event paths
  function automatic ts_fields_t mask_fields(ts_fields_t f, logic [PCNT_W-1:0] pairs);
    ts_fields_t m;
    m = f;
    if (pairs == '0) begin
      m = '0;
    end else if (f.evt_pair) begin
      m.evt_sel[SEL_W-1] = 1'b0;
    end
    return m;
  endfunction
endpackage

// File: rtl/ts_ctl_decode.sv
`timescale 1ns/1ps
module ts_ctl_decode
  import ts_ctl_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] op0_i,
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  output logic       hit_o
);
  logic enc_match;

  assign enc_match = (op0_i == ENC_OP0) && (op1_i == ENC_OP1) &&
                     (crn_i == ENC_CRN) && (crm_i == ENC_CRM) &&
                     (op2_i == ENC_OP2);
  assign hit_o = valid_i && enc_match;
endmodule

// File: rtl/ts_ctl_trap.sv
`timescale 1ns/1ps
module ts_ctl_trap
  import ts_ctl_pkg::*;
(
  input  logic            hit_i,
  input  logic [1:0]      cur_el_i,
  input  logic            el1_tta_i,
  input  logic            el2_tta_i,
  input  logic            el3_tta_i,
  input  logic            el2_en_i,
  input  logic            el2_aa32_i,
  input  logic            el3_present_i,
  input  logic            el3_aa32_i,
  input  logic [TS_W-1:0] ts_size_i,
  output logic            done_o,
  output logic            undef_o,
  output logic            trap_o,
  output logic [1:0]      trap_el_o
);
  logic reg_present;
  logic el2_gate;
  logic el3_gate;
  lvl_e cur_lvl;

  assign reg_present = (ts_size_i != '0);
  assign el2_gate    = el2_en_i && !el2_aa32_i && el2_tta_i;
  assign el3_gate    = el3_present_i && !el3_aa32_i && el3_tta_i;
  assign cur_lvl     = lvl_e'(cur_el_i);

  always_comb begin
    done_o    = 1'b0;
    undef_o   = 1'b0;
    trap_o    = 1'b0;
    trap_el_o = LVL0;
    if (hit_i) begin
      if (!reg_present || cur_lvl == LVL0) begin
        undef_o = 1'b1;
      end else begin
        unique case (cur_lvl)
          LVL1: begin
            if (el1_tta_i) begin
              trap_o = 1'b1; trap_el_o = LVL1;
            end else if (el2_gate) begin
              trap_o = 1'b1; trap_el_o = LVL2;
            end else if (el3_gate) begin
              trap_o = 1'b1; trap_el_o = LVL3;
            end else begin
              done_o = 1'b1;
            end
          end
          LVL2: begin
            if (el2_tta_i) begin
              trap_o = 1'b1; trap_el_o = LVL2;
            end else if (el3_gate) begin
              trap_o = 1'b1; trap_el_o = LVL3;
            end else begin
              done_o = 1'b1;
            end
          end
          default: begin
            if (el3_tta_i) begin
              trap_o = 1'b1; trap_el_o = LVL3;
            end else begin
              done_o = 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ts_ctl_store.sv
`timescale 1ns/1ps
module ts_ctl_store
  import ts_ctl_pkg::*;
#(
  parameter logic             RST_PAIR = 1'b0,
  parameter logic [SEL_W-1:0] RST_SEL  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  ts_fields_t        wfields_i,
  input  logic [PCNT_W-1:0] pairs_i,
  output ts_fields_t        fields_o
);
  ts_fields_t fields_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fields_q.evt_pair <= RST_PAIR;
      fields_q.evt_sel  <= RST_SEL;
    end else if (we_i) begin
      fields_q <= mask_fields(wfields_i, pairs_i);
    end
  end

  assign fields_o = fields_q;
endmodule

// File: rtl/ts_ctl_event.sv
`timescale 1ns/1ps
module ts_ctl_event
  import ts_ctl_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  ts_fields_t           fields_i,
  input  logic [PCNT_W-1:0]    pairs_i,
  input  logic [NUM_SEL-1:0]   res_status_i,
  input  logic [NUM_PAIRS-1:0] pair_result_i,
  output logic                 req_o
);
  logic [NUM_SEL-1:0]   single_impl;
  logic [NUM_PAIRS-1:0] pair_impl;
  logic [PCNT_W:0]      single_cnt;
  ts_fields_t           eff;
  logic [PAIR_W-1:0]    pair_idx;
  logic                 req_d;
  logic                 req_q;

  assign single_cnt = {pairs_i, 1'b0};

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_single
    assign single_impl[g] = (32'(g) < 32'(single_cnt));
  end
  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    assign pair_impl[g] = (32'(g) < 32'(pairs_i));
  end

  assign eff      = mask_fields(fields_i, pairs_i);
  assign pair_idx = eff.evt_sel[PAIR_W-1:0];

  always_comb begin
    if (eff.evt_pair) begin
      req_d = pair_result_i[pair_idx] && pair_impl[pair_idx];
    end else begin
      req_d = res_status_i[eff.evt_sel] && single_impl[eff.evt_sel];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/ts_ctl_reg.sv
`timescale 1ns/1ps
module ts_ctl_reg
  import ts_ctl_pkg::*;
#(
  parameter logic             RST_PAIR = 1'b0,
  parameter logic [SEL_W-1:0] RST_SEL  = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 acc_valid_i,
  input  logic                 acc_write_i,
  input  logic [1:0]           acc_op0_i,
  input  logic [2:0]           acc_op1_i,
  input  logic [3:0]           acc_crn_i,
  input  logic [3:0]           acc_crm_i,
  input  logic [2:0]           acc_op2_i,
  input  logic [REG_W-1:0]     acc_wdata_i,
  input  logic [1:0]           cur_el_i,
  input  logic                 el1_tta_i,
  input  logic                 el2_tta_i,
  input  logic                 el3_tta_i,
  input  logic                 el2_en_i,
  input  logic                 el2_aa32_i,
  input  logic                 el3_present_i,
  input  logic                 el3_aa32_i,
  input  logic                 unit_idle_i,
  input  logic [TS_W-1:0]      cfg_ts_size_i,
  input  logic [PCNT_W-1:0]    cfg_pairs_i,
  input  logic [NUM_SEL-1:0]   res_status_i,
  input  logic [NUM_PAIRS-1:0] pair_result_i,
  output logic                 acc_done_o,
  output logic                 acc_undef_o,
  output logic                 acc_trap_o,
  output logic [1:0]           trap_el_o,
  output logic [5:0]           trap_ec_o,
  output logic [REG_W-1:0]     rdata_o,
  output logic                 wr_ack_o,
  output logic                 wr_unpred_o,
  output logic                 ts_req_o
);
  logic       acc_hit;
  logic       done;
  logic       wr_en;
  ts_fields_t wr_fields;
  ts_fields_t state_q;
  ts_fields_t rd_fields;
  logic       wdata_unused;

  ts_ctl_decode u_decode (
    .valid_i (acc_valid_i),
    .op0_i   (acc_op0_i),
    .op1_i   (acc_op1_i),
    .crn_i   (acc_crn_i),
    .crm_i   (acc_crm_i),
    .op2_i   (acc_op2_i),
    .hit_o   (acc_hit)
  );

  ts_ctl_trap u_trap (
    .hit_i         (acc_hit),
    .cur_el_i      (cur_el_i),
    .el1_tta_i     (el1_tta_i),
    .el2_tta_i     (el2_tta_i),
    .el3_tta_i     (el3_tta_i),
    .el2_en_i      (el2_en_i),
    .el2_aa32_i    (el2_aa32_i),
    .el3_present_i (el3_present_i),
    .el3_aa32_i    (el3_aa32_i),
    .ts_size_i     (cfg_ts_size_i),
    .done_o        (done),
    .undef_o       (acc_undef_o),
    .trap_o        (acc_trap_o),
    .trap_el_o     (trap_el_o)
  );

  assign wr_fields.evt_pair = acc_wdata_i[TYPE_POS];
  assign wr_fields.evt_sel  = acc_wdata_i[SEL_W-1:0];
  assign wdata_unused = ^{acc_wdata_i[REG_W-1:TYPE_POS+1], acc_wdata_i[TYPE_POS-1:SEL_W]};
  assign wr_en = done && acc_write_i;

  ts_ctl_store #(
    .RST_PAIR (RST_PAIR),
    .RST_SEL  (RST_SEL)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en),
    .wfields_i (wr_fields),
    .pairs_i   (cfg_pairs_i),
    .fields_o  (state_q)
  );

  ts_ctl_event u_event (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fields_i      (state_q),
    .pairs_i       (cfg_pairs_i),
    .res_status_i  (res_status_i),
    .pair_result_i (pair_result_i),
    .req_o         (ts_req_o)
  );

  assign rd_fields = mask_fields(state_q, cfg_pairs_i);

  always_comb begin
    rdata_o = '0;
    if (done && !acc_write_i) begin
      rdata_o[TYPE_POS]      = rd_fields.evt_pair;
      rdata_o[SEL_W-1:0]     = rd_fields.evt_sel;
    end
  end

  assign acc_done_o  = done;
  assign trap_ec_o   = acc_trap_o ? TRAP_EC : 6'h00;
  assign wr_ack_o    = wr_en;
  assign wr_unpred_o = wr_en && !unit_idle_i;
endmodule

// File: rtl/ts_ctl_chk.sv
`timescale 1ns/1ps
module ts_ctl_chk
  import ts_ctl_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_hit,
  input logic             acc_done_o,
  input logic             acc_undef_o,
  input logic             acc_trap_o,
  input logic [1:0]       trap_el_o,
  input logic [5:0]       trap_ec_o,
  input logic [1:0]       cur_el_i,
  input logic [REG_W-1:0] rdata_o,
  input logic             wr_ack_o,
  input logic             wr_unpred_o,
  input logic             unit_idle_i,
  input ts_fields_t       state_q
);
  AST_RESP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_done_o, acc_undef_o, acc_trap_o})); // R3

  AST_HIT_RESPONDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_hit |-> $countones({acc_done_o, acc_undef_o, acc_trap_o}) == 1); // R3

  AST_MISS_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_hit |-> !(acc_done_o || acc_undef_o || acc_trap_o)); // R2

  AST_EL0_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_hit && cur_el_i == 2'd0) |-> acc_undef_o); // R4

  AST_TRAP_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_trap_o |-> trap_ec_o == TRAP_EC); // R3

  AST_TRAP_NOT_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_trap_o |-> trap_el_o >= cur_el_i); // R6

  AST_EL3_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_trap_o && cur_el_i == 2'd3) |-> trap_el_o == 2'd3); // R8

  AST_RDATA_RES0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[REG_W-1:TYPE_POS+1] == '0 && rdata_o[TYPE_POS-1:SEL_W] == '0); // R9

  AST_UNPRED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_unpred_o |-> (wr_ack_o && !unit_idle_i)); // R11

  AST_STATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ack_o |=> $stable(state_q)); // R12
endmodule

bind ts_ctl_reg ts_ctl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_hit     (acc_hit),
  .acc_done_o  (acc_done_o),
  .acc_undef_o (acc_undef_o),
  .acc_trap_o  (acc_trap_o),
  .trap_el_o   (trap_el_o),
  .trap_ec_o   (trap_ec_o),
  .cur_el_i    (cur_el_i),
  .rdata_o     (rdata_o),
  .wr_ack_o    (wr_ack_o),
  .wr_unpred_o (wr_unpred_o),
  .unit_idle_i (unit_idle_i),
  .state_q     (state_q)
);

// File: tb/sim_ts_ctl_reg.sv
`timescale 1ns/1ps
module sim_ts_ctl_reg;
  localparam int K_NONE  = 0;
  localparam int K_DONE  = 1;
  localparam int K_UNDEF = 2;
  localparam int K_TRAP  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [3:0]  enc_crm = 4'b1100;
  logic [63:0] acc_wdata = '0;
  logic [1:0]  cur_el = 2'd0;
  logic        el1_tta = 0, el2_tta = 0, el3_tta = 0;
  logic        el2_en = 0, el2_aa32 = 0, el3_present = 1, el3_aa32 = 0;
  logic        idle = 1;
  logic [4:0]  ts_size = 5'd8;
  logic [4:0]  pairs = 5'd16;
  logic [31:0] res_status = '0;
  logic [15:0] pair_result = '0;
  logic        done, undef, trap, wr_ack, wr_unpred, ts_req;
  logic [1:0]  trap_el;
  logic [5:0]  trap_ec;
  logic [63:0] rdata;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    int          kind;
    logic [1:0]  tel;
    logic [63:0] rd;
    bit          ack;
    bit          un;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  ts_ctl_reg u0 (
    .clk_i (clk), .rst_ni (rst_n),
    .acc_valid_i (acc_valid), .acc_write_i (acc_write),
    .acc_op0_i (2'b10), .acc_op1_i (3'b001), .acc_crn_i (4'b0000),
    .acc_crm_i (enc_crm), .acc_op2_i (3'b000), .acc_wdata_i (acc_wdata),
    .cur_el_i (cur_el), .el1_tta_i (el1_tta), .el2_tta_i (el2_tta), .el3_tta_i (el3_tta),
    .el2_en_i (el2_en), .el2_aa32_i (el2_aa32), .el3_present_i (el3_present),
    .el3_aa32_i (el3_aa32), .unit_idle_i (idle),
    .cfg_ts_size_i (ts_size), .cfg_pairs_i (pairs),
    .res_status_i (res_status), .pair_result_i (pair_result),
    .acc_done_o (done), .acc_undef_o (undef), .acc_trap_o (trap),
    .trap_el_o (trap_el), .trap_ec_o (trap_ec), .rdata_o (rdata),
    .wr_ack_o (wr_ack), .wr_unpred_o (wr_unpred), .ts_req_o (ts_req)
  );

  task automatic report(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // driver: one access cycle, expected outcome pushed to the scoreboard
  task automatic do_acc(input bit wr, input logic [63:0] wd, input logic [1:0] el,
                        input int kind, input logic [1:0] tel, input logic [63:0] erd,
                        input bit eun, input string tag);
    exp_t e;
    @(negedge clk);
    acc_write = wr;
    acc_wdata = wd;
    cur_el    = el;
    acc_valid = 1'b1;
    e.kind = kind; e.tel = tel; e.rd = erd;
    e.ack  = wr && (kind == K_DONE); e.un = eun; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    acc_valid = 1'b0;
    acc_write = 1'b0;
  endtask

  task automatic chk_req_next(input bit expv, input string tag);
    @(negedge clk);
    #5;
    report(ts_req == expv, tag, "ts_req", 64'(ts_req), 64'(expv));
  endtask

  // monitor: compares scoreboard items against the ports in the strobe cycle
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sb_q.size() > 0) begin
        exp_t e;
        int   ak;
        e = sb_q.pop_front();
        ak = 9;
        if (!done && !undef && !trap) ak = K_NONE;
        else if (done && !undef && !trap) ak = K_DONE;
        else if (!done && undef && !trap) ak = K_UNDEF;
        else if (!done && !undef && trap) ak = K_TRAP;
        report(ak == e.kind, e.tag, "outcome", 64'(ak), 64'(e.kind));
        if (e.kind == K_TRAP) begin
          report(trap_el == e.tel, e.tag, "trap_el", 64'(trap_el), 64'(e.tel));
          report(trap_ec == 6'h18, e.tag, "trap_ec", 64'(trap_ec), 64'h18);
        end
        report(rdata == e.rd, e.tag, "rdata", rdata, e.rd);
        report(wr_ack == e.ack, e.tag, "wr_ack", 64'(wr_ack), 64'(e.ack));
        report(wr_unpred == e.un, e.tag, "wr_unpred", 64'(wr_unpred), 64'(e.un));
      end
    end
  end

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    report({done, undef, trap, wr_ack, wr_unpred, ts_req} == 6'b0, "R1", "idle outputs",
           64'({done, undef, trap, wr_ack, wr_unpred, ts_req}), 64'h0);

    // R9 layout and pair masking of sel[4]
    do_acc(1, 64'hFFFF_FFFF_FFFF_FF85, 2'd1, K_DONE, 0, 0, 0, "R9");
    do_acc(0, 0, 2'd1, K_DONE, 0, 64'h85, 0, "R9");
    do_acc(1, 64'hFFFF_FFFF_FFFF_FF9F, 2'd1, K_DONE, 0, 0, 0, "R9");
    do_acc(0, 0, 2'd1, K_DONE, 0, 64'h8F, 0, "R9");
    do_acc(1, 64'hFFFF_FFFF_FFFF_FF7F, 2'd1, K_DONE, 0, 0, 0, "R9");
    do_acc(0, 0, 2'd1, K_DONE, 0, 64'h1F, 0, "R9");

    // R2 foreign encoding
    enc_crm = 4'b1101;
    do_acc(1, 64'h80, 2'd1, K_NONE, 0, 0, 0, "R2");
    do_acc(0, 0, 2'd1, K_NONE, 0, 0, 0, "R2");
    enc_crm = 4'b1100;
    do_acc(0, 0, 2'd1, K_DONE, 0, 64'h1F, 0, "R2");

    // R4 EL0, R12 undefined write is ignored
    do_acc(0, 0, 2'd0, K_UNDEF, 0, 0, 0, "R4");
    do_acc(1, 64'h0, 2'd0, K_UNDEF, 0, 0, 0, "R4");
    do_acc(0, 0, 2'd3, K_DONE, 0, 64'h1F, 0, "R12");

    // R5 absent register
    ts_size = 5'd0;
    do_acc(0, 0, 2'd3, K_UNDEF, 0, 0, 0, "R5");
    do_acc(1, 64'h3, 2'd1, K_UNDEF, 0, 0, 0, "R5");
    ts_size = 5'd8;

    // R6 EL1 priority
    el1_tta = 1; el2_en = 1; el2_tta = 1; el3_tta = 1;
    do_acc(0, 0, 2'd1, K_TRAP, 2'd1, 0, 0, "R6");
    el1_tta = 0;
    do_acc(0, 0, 2'd1, K_TRAP, 2'd2, 0, 0, "R6");
    el2_en = 0;
    do_acc(0, 0, 2'd1, K_TRAP, 2'd3, 0, 0, "R6");
    el2_en = 1; el2_aa32 = 1;
    do_acc(0, 0, 2'd1, K_TRAP, 2'd3, 0, 0, "R6");
    el3_aa32 = 1;
    do_acc(0, 0, 2'd1, K_DONE, 0, 64'h1F, 0, "R6");
    el3_aa32 = 0; el3_present = 0;
    do_acc(0, 0, 2'd1, K_DONE, 0, 64'h1F, 0, "R6");
    el3_present = 1; el2_aa32 = 0;

    // R7 EL2
    el2_en = 0; el2_tta = 1; el3_tta = 1;
    do_acc(0, 0, 2'd2, K_TRAP, 2'd2, 0, 0, "R7");
    el2_tta = 0;
    do_acc(0, 0, 2'd2, K_TRAP, 2'd3, 0, 0, "R7");
    el3_tta = 0;
    do_acc(0, 0, 2'd2, K_DONE, 0, 64'h1F, 0, "R7");

    // R8 EL3 and R12 trapped write ignored
    el1_tta = 1; el2_tta = 1; el2_en = 1;
    do_acc(0, 0, 2'd3, K_DONE, 0, 64'h1F, 0, "R8");
    el3_tta = 1;
    do_acc(1, 64'h85, 2'd3, K_TRAP, 2'd3, 0, 0, "R8");
    el1_tta = 0; el2_tta = 0; el3_tta = 0; el2_en = 0;
    do_acc(0, 0, 2'd3, K_DONE, 0, 64'h1F, 0, "R12");

    // R11 non-idle write still lands
    idle = 0;
    do_acc(1, 64'h83, 2'd2, K_DONE, 0, 0, 1, "R11");
    idle = 1;
    do_acc(0, 0, 2'd2, K_DONE, 0, 64'h83, 0, "R11");
    do_acc(1, 64'h84, 2'd2, K_DONE, 0, 0, 0, "R11");

    // R10 no pairs
    pairs = 5'd0;
    do_acc(1, 64'h9F, 2'd1, K_DONE, 0, 0, 0, "R10");
    do_acc(0, 0, 2'd1, K_DONE, 0, 64'h0, 0, "R10");
    res_status = '1; pair_result = '1;
    chk_req_next(1'b0, "R10");
    pairs = 5'd16;
    do_acc(0, 0, 2'd1, K_DONE, 0, 64'h0, 0, "R10");

    // R13 single selector, four pairs -> eight singles
    pairs = 5'd4; res_status = 32'h0000_0008; pair_result = '0;
    do_acc(1, 64'h03, 2'd3, K_DONE, 0, 0, 0, "R13");
    chk_req_next(1'b1, "R13");
    do_acc(1, 64'h07, 2'd3, K_DONE, 0, 0, 0, "R13");
    #5;
    report(ts_req == 1'b1, "R13", "ts_req old selection", 64'(ts_req), 64'h1);
    chk_req_next(1'b0, "R13");
    res_status = 32'h0000_0080;
    chk_req_next(1'b1, "R13");
    res_status = '1;
    do_acc(1, 64'h09, 2'd3, K_DONE, 0, 0, 0, "R13");
    chk_req_next(1'b0, "R13");

    // R14 pair selector
    res_status = '1; pair_result = 16'h0004;
    do_acc(1, 64'h82, 2'd3, K_DONE, 0, 0, 0, "R14");
    chk_req_next(1'b1, "R14");
    pair_result = 16'hFFFB;
    chk_req_next(1'b0, "R14");
    pair_result = '1;
    do_acc(1, 64'h85, 2'd3, K_DONE, 0, 0, 0, "R14");
    chk_req_next(1'b0, "R14");
    pairs = 5'd16;
    chk_req_next(1'b1, "R14");

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule